// File: doc/BRIEF.md
# Supervisory Power Mode Controller

This block is the mode sequencer of a system basis chip. It holds the chip in one of seven modes: Power Down, Reset, Normal Request, Normal, Standby, Stop and Sleep. It moves between them on:

- already decoded serial mode commands,
- watchdog refresh writes,
- rising edges of the serial chip select,
- supply and battery status flags,
- two configuration bits (no-stop and battery-fail),
- wake-up requests.

All timing comes from an external millisecond strobe, and every period is a parameter counted in strobes. A single state timer serves the Reset period and the watchdog period of each mode. The timer is cleared whenever the mode changes and on every accepted watchdog refresh.

Transitions, by state, with conditions listed in priority order:

- **Power Down** goes to Reset (power-up).
- **Reset** goes to Sleep on a hot supply, or on a supply that has been low for long enough, provided the battery is above its early-warning level and low power is allowed (forced sleep). Otherwise it goes to Normal Request when the reset period expires.
- **Normal Request** goes to:
  - Reset on a bad supply;
  - Sleep or Reset when its watchdog expires;
  - Standby on the standby pair;
  - Normal on a refresh.
- **Normal and Standby** go to:
  - Reset on a bad supply;
  - Reset on a watchdog timeout or a refresh outside the window;
  - Sleep on the sleep command;
  - Stop on the stop pair.

  In addition, Normal goes to Standby on the standby pair, and Standby goes to Normal on the normal command.
- **Stop** goes to Reset on a bad supply or watchdog expiry, and to Normal Request on a wake-up.
- **Sleep** goes to Reset on a wake-up.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (Power Down), rst_o is 1 and wd_to_o is 0. The first clock edge after release moves mode_o to 1 (Reset).
- R2: Reset lasts RST_TICKS strobes and then moves to mode 2 (Normal Request). rst_o is 1 only in modes 0 and 1.
- R3: In Normal Request, a refresh moves to mode 3 (Normal). If NREQ_TICKS strobes pass without a refresh, wd_to_o is set and the mode moves to 6 (Sleep) when no-stop and battery-fail are both 0, and to 1 (Reset) otherwise.
- R4: In Normal and Standby, WD_TICKS strobes without a refresh move the mode to Reset with wd_to_o set. An accepted refresh restarts the count and clears wd_to_o.
- R5: With win_en_i at 1 in Normal or Standby, a refresh that arrives fewer than WIN_TICKS strobes after the last restart is a timeout: the mode moves to Reset and wd_to_o is set.
- R6: Command code 2 (standby) followed, as the very next event, by a refresh moves Normal Request or Normal to mode 4 (Standby). Any other event in between discards the pending step.
- R7: Command code 3 (stop) followed, as the very next event, by a chip-select rising edge moves Normal or Standby to mode 5 (Stop), but only when no-stop is 0. An intervening event discards the pending step.
- R8: Command code 4 (sleep) in Normal or Standby moves to Sleep only when no-stop and battery-fail are both 0. Otherwise it has no effect.
- R9: A low or hot supply in Normal Request, Normal or Standby moves the mode to Reset at the next edge. This takes priority over any command or refresh in the same cycle.
- R10: In Stop, a chip-select rising edge, a bus wake-up or an enabled timed wake-up moves the mode to Normal Request. In Sleep, the same events move it to Reset.
- R11: The forced wake-up input acts only when fwu_en_i is 1. The cyclic-sense wake-up input acts only when cyc_en_i is 1 and fwu_en_i is 0.
- R12: In Stop, STOP_TICKS strobes without a refresh move the mode to Reset with wd_to_o set. The window rule does not apply in Stop: an early refresh restarts the count.
- R13: In Reset, a hot supply (or a supply low for LOW_TICKS strobes) moves the mode to Sleep when vsup_ok_i is 1 and no-stop and battery-fail are both 0. Otherwise the mode stays in Reset while the condition lasts.
- R14: Command code 1 (normal) in Standby moves the mode to Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| cmd_valid_i | input | 1 | Decoded mode command present |
| cmd_code_i | input | 3 | Command code: 1 normal, 2 standby, 3 stop, 4 sleep |
| wd_trig_i | input | 1 | Watchdog refresh write |
| win_en_i | input | 1 | Windowed watchdog enable |
| cs_i | input | 1 | Serial chip select level (idle high) |
| vdd_low_i | input | 1 | Regulated supply below reset threshold |
| vdd_hot_i | input | 1 | Regulated supply overtemperature |
| vsup_ok_i | input | 1 | Battery above early-warning level |
| batfail_i | input | 1 | Battery-fail bit |
| nostop_i | input | 1 | No-stop bit |
| fwu_en_i | input | 1 | Forced wake-up enable |
| cyc_en_i | input | 1 | Cyclic-sense wake-up enable |
| wake_bus_i | input | 1 | Bus wake-up request |
| wake_forced_i | input | 1 | Forced wake-up timer request |
| wake_cyclic_i | input | 1 | Cyclic-sense wake-up request |
| mode_o | output | 3 | Current mode: 0 Power Down, 1 Reset, 2 Normal Request, 3 Normal, 4 Standby, 5 Stop, 6 Sleep |
| rst_o | output | 1 | Reset output, high in Power Down and Reset |
| wd_to_o | output | 1 | Watchdog timeout flag |

## Verification
Every command, refresh, chip-select edge, supply flag and wake-up is seen at the first rising edge where it is present. Its result on mode_o and wd_to_o is therefore due one edge later. The bench drives each stimulus on a falling edge and reads the outputs on the next falling edge.

A period expires one edge after the strobe that brings the count to its limit. Each timed case therefore checks one strobe before the limit (the mode is unchanged) and again at the limit (the mode has changed). Each check uses the same falling-edge sampling point.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        M_PDOWN  = 3'd0,
        M_RESET  = 3'd1,
        M_NREQ   = 3'd2,
        M_NORMAL = 3'd3,
        M_STBY   = 3'd4,
        M_STOP   = 3'd5,
        M_SLEEP  = 3'd6
    } pmc_mode_e;

    localparam logic [2:0] CMD_NORMAL = 3'd1;
    localparam logic [2:0] CMD_STBY   = 3'd2;
    localparam logic [2:0] CMD_STOP   = 3'd3;
    localparam logic [2:0] CMD_SLEEP  = 3'd4;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmc_tick_cnt.sv
// Saturating strobe counter with synchronous clear.
module pmc_tick_cnt #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (tick_i && (cnt_o != CNT_TOP)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/pmc_entry_seq.sv
// Tracks the two-step entry sequences and detects chip-select rising edges.
module pmc_entry_seq
    import pmc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       flush_i,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_code_i,
    input  logic       wd_trig_i,
    input  logic       cs_i,
    output logic       cs_rise_o,
    output logic       stby_go_o,
    output logic       stop_go_o
);
    logic cs_q;
    logic pend_stby;
    logic pend_stop;
    logic any_evt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q <= 1'b1;
        end else begin
            cs_q <= cs_i;
        end
    end

    assign cs_rise_o = cs_i & ~cs_q;
    assign any_evt   = cmd_valid_i | wd_trig_i | cs_rise_o;

    // Every event replaces the pending step; only a matching command arms one.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_stby <= 1'b0;
            pend_stop <= 1'b0;
        end else if (flush_i) begin
            pend_stby <= 1'b0;
            pend_stop <= 1'b0;
        end else if (any_evt) begin
            pend_stby <= cmd_valid_i && (cmd_code_i == CMD_STBY);
            pend_stop <= cmd_valid_i && (cmd_code_i == CMD_STOP);
        end
    end

    assign stby_go_o = pend_stby & wd_trig_i & ~cmd_valid_i & ~cs_rise_o;
    assign stop_go_o = pend_stop & cs_rise_o & ~cmd_valid_i & ~wd_trig_i;
endmodule

// File: rtl/pmc_wake_sel.sv
// Merges wake-up sources, applying the exclusive timed-wake enables.
module pmc_wake_sel #(
    parameter int NSRC = 4
) (
    input  logic            cs_rise_i,
    input  logic            wake_bus_i,
    input  logic            wake_forced_i,
    input  logic            wake_cyclic_i,
    input  logic            fwu_en_i,
    input  logic            cyc_en_i,
    output logic            wake_o
);
    logic [NSRC-1:0] src;
    logic [NSRC-1:0] msk;
    logic [NSRC-1:0] hit;

    assign src = {wake_cyclic_i, wake_forced_i, wake_bus_i, cs_rise_i};
    assign msk = {cyc_en_i & ~fwu_en_i, fwu_en_i, 1'b1, 1'b1};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src[g] & msk[g];
    end

    assign wake_o = |hit;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int RST_TICKS  = 4,
    parameter int NREQ_TICKS = 350,
    parameter int WD_TICKS   = 128,
    parameter int WIN_TICKS  = 64,
    parameter int STOP_TICKS = 512,
    parameter int LOW_TICKS  = 100
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ms_tick_i,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_code_i,
    input  logic       wd_trig_i,
    input  logic       win_en_i,
    input  logic       cs_i,
    input  logic       vdd_low_i,
    input  logic       vdd_hot_i,
    input  logic       vsup_ok_i,
    input  logic       batfail_i,
    input  logic       nostop_i,
    input  logic       fwu_en_i,
    input  logic       cyc_en_i,
    input  logic       wake_bus_i,
    input  logic       wake_forced_i,
    input  logic       wake_cyclic_i,
    output logic [2:0] mode_o,
    output logic       rst_o,
    output logic       wd_to_o
);
    localparam int TMAX = imax(imax(RST_TICKS, NREQ_TICKS),
                               imax(imax(WD_TICKS, WIN_TICKS), STOP_TICKS));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int LW   = $clog2(LOW_TICKS + 1);

    localparam logic [TW-1:0] L_RST  = TW'(RST_TICKS);
    localparam logic [TW-1:0] L_NREQ = TW'(NREQ_TICKS);
    localparam logic [TW-1:0] L_WD   = TW'(WD_TICKS);
    localparam logic [TW-1:0] L_WIN  = TW'(WIN_TICKS);
    localparam logic [TW-1:0] L_STOP = TW'(STOP_TICKS);
    localparam logic [LW-1:0] L_LOW  = LW'(LOW_TICKS);

    pmc_mode_e state_q, state_d;

    logic [TW-1:0] tmr_cnt;
    logic [LW-1:0] low_cnt;
    logic          tmr_clr;
    logic          cs_rise, stby_go, stop_go, wake;
    logic          supply_bad, low_long, lp_ok;
    logic          wd_state, early, trig_ok, trig_bad, expired;
    logic [TW-1:0] wd_limit;
    logic          to_evt;
    logic          mode_chg;

    // ---------------------------------------------------------- helpers
    pmc_tick_cnt #(.W(TW)) u_state_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .tick_i (ms_tick_i),
        .cnt_o  (tmr_cnt)
    );

    pmc_tick_cnt #(.W(LW)) u_low_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (~vdd_low_i),
        .tick_i (ms_tick_i),
        .cnt_o  (low_cnt)
    );

    pmc_entry_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (mode_chg),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .wd_trig_i   (wd_trig_i),
        .cs_i        (cs_i),
        .cs_rise_o   (cs_rise),
        .stby_go_o   (stby_go),
        .stop_go_o   (stop_go)
    );

    pmc_wake_sel #(.NSRC(4)) u_wake (
        .cs_rise_i     (cs_rise),
        .wake_bus_i    (wake_bus_i),
        .wake_forced_i (wake_forced_i),
        .wake_cyclic_i (wake_cyclic_i),
        .fwu_en_i      (fwu_en_i),
        .cyc_en_i      (cyc_en_i),
        .wake_o        (wake)
    );

    // ---------------------------------------------------- watchdog view
    assign supply_bad = vdd_low_i | vdd_hot_i;
    assign low_long   = (low_cnt >= L_LOW);
    assign lp_ok      = ~nostop_i & ~batfail_i;

    always_comb begin
        wd_state = 1'b1;
        wd_limit = L_WD;
        unique case (state_q)
            M_NREQ:           wd_limit = L_NREQ;
            M_NORMAL, M_STBY: wd_limit = L_WD;
            M_STOP:           wd_limit = L_STOP;
            default: begin
                wd_state = 1'b0;
                wd_limit = L_WD;
            end
        endcase
    end

    assign early    = win_en_i && ((state_q == M_NORMAL) || (state_q == M_STBY))
                      && (tmr_cnt < L_WIN);
    assign trig_ok  = wd_state & wd_trig_i & ~early;
    assign trig_bad = wd_state & wd_trig_i & early;
    assign expired  = wd_state & (tmr_cnt >= wd_limit);

    // ------------------------------------------------ next-state logic
    always_comb begin
        state_d = state_q;
        to_evt  = 1'b0;
        unique case (state_q)
            M_PDOWN: begin
                state_d = M_RESET;
            end
            M_RESET: begin
                if ((vdd_hot_i || low_long) && vsup_ok_i && lp_ok) begin
                    state_d = M_SLEEP;
                end else if (!supply_bad && (tmr_cnt >= L_RST)) begin
                    state_d = M_NREQ;
                end
            end
            M_NREQ: begin
                if (supply_bad) begin
                    state_d = M_RESET;
                end else if (expired) begin
                    to_evt  = 1'b1;
                    state_d = lp_ok ? M_SLEEP : M_RESET;
                end else if (stby_go) begin
                    state_d = M_STBY;
                end else if (wd_trig_i) begin
                    state_d = M_NORMAL;
                end
            end
            M_NORMAL, M_STBY: begin
                if (supply_bad) begin
                    state_d = M_RESET;
                end else if (expired || trig_bad) begin
                    to_evt  = 1'b1;
                    state_d = M_RESET;
                end else if (cmd_valid_i && (cmd_code_i == CMD_SLEEP) && lp_ok) begin
                    state_d = M_SLEEP;
                end else if (stop_go && !nostop_i) begin
                    state_d = M_STOP;
                end else if ((state_q == M_NORMAL) && stby_go) begin
                    state_d = M_STBY;
                end else if ((state_q == M_STBY) && cmd_valid_i
                             && (cmd_code_i == CMD_NORMAL)) begin
                    state_d = M_NORMAL;
                end
            end
            M_STOP: begin
                if (supply_bad) begin
                    state_d = M_RESET;
                end else if (expired) begin
                    to_evt  = 1'b1;
                    state_d = M_RESET;
                end else if (wake) begin
                    state_d = M_NREQ;
                end
            end
            M_SLEEP: begin
                if (wake) begin
                    state_d = M_RESET;
                end
            end
            default: begin
                state_d = M_RESET;
            end
        endcase
    end

    assign mode_chg = (state_d != state_q);
    assign tmr_clr  = mode_chg | trig_ok | ((state_q == M_RESET) & supply_bad);

    // ---------------------------------------------------- state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= M_PDOWN;
            wd_to_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (to_evt) begin
                wd_to_o <= 1'b1;
            end else if (trig_ok) begin
                wd_to_o <= 1'b0;
            end
        end
    end

    // ------------------------------------------------------------ outputs
    always_comb begin
        mode_o = state_q;
        rst_o  = (state_q == M_PDOWN) || (state_q == M_RESET);
    end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] mode_o,
    input logic       wd_to_o,
    input logic       nostop_i,
    input logic       batfail_i,
    input logic       vdd_low_i
);
    // R1
    mode_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o <= 3'd6);

    // R2
    nreq_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd2 && $past(mode_o) != 3'd2)
        |-> ($past(mode_o) == 3'd1 || $past(mode_o) == 3'd5));

    // R4
    wd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wd_to_o) |-> (mode_o == 3'd1 || mode_o == 3'd6));

    // R7
    stop_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd5 && $past(mode_o) != 3'd5) |-> !$past(nostop_i));

    // R8
    sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd6 && $past(mode_o) != 3'd6)
        |-> (!$past(nostop_i) && !$past(batfail_i)));

    // R9
    supply_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vdd_low_i && (mode_o == 3'd2 || mode_o == 3'd3 || mode_o == 3'd4))
        |=> mode_o == 3'd1);

    // R10
    sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_o) == 3'd6 && mode_o != 3'd6) |-> mode_o == 3'd1);
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_o    (mode_o),
    .wd_to_o   (wd_to_o),
    .nostop_i  (nostop_i),
    .batfail_i (batfail_i),
    .vdd_low_i (vdd_low_i)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
    localparam int P_RST  = 3;
    localparam int P_NREQ = 6;
    localparam int P_WD   = 8;
    localparam int P_WIN  = 4;
    localparam int P_STOP = 10;
    localparam int P_LOW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, cmd_v = 0, trig = 0, win = 0, cs = 1;
    logic [2:0] code = 3'd0;
    logic vlow = 0, vhot = 0, vsup = 1, bfail = 0, nstop = 0;
    logic fwu = 0, cyc = 0, wbus = 0, wfrc = 0, wcyc = 0;
    logic [2:0] mode;
    logic rsto, wdto;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(
        .RST_TICKS(P_RST), .NREQ_TICKS(P_NREQ), .WD_TICKS(P_WD),
        .WIN_TICKS(P_WIN), .STOP_TICKS(P_STOP), .LOW_TICKS(P_LOW)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .cmd_valid_i(cmd_v),
        .cmd_code_i(code), .wd_trig_i(trig), .win_en_i(win), .cs_i(cs),
        .vdd_low_i(vlow), .vdd_hot_i(vhot), .vsup_ok_i(vsup),
        .batfail_i(bfail), .nostop_i(nstop), .fwu_en_i(fwu), .cyc_en_i(cyc),
        .wake_bus_i(wbus), .wake_forced_i(wfrc), .wake_cyclic_i(wcyc),
        .mode_o(mode), .rst_o(rsto), .wd_to_o(wdto)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0;
        end
    endtask

    task automatic cmd(input logic [2:0] c);
        cmd_v = 1'b1; code = c; step(); cmd_v = 1'b0; code = 3'd0;
    endtask

    task automatic refresh();
        trig = 1'b1; step(); trig = 1'b0;
    endtask

    task automatic cs_pulse();
        cs = 1'b0; step(); cs = 1'b1; step();
    endtask

    task automatic wake_pulse(input int which);
        if (which == 0) wbus = 1'b1;
        else if (which == 1) wfrc = 1'b1;
        else wcyc = 1'b1;
        step();
        wbus = 1'b0; wfrc = 1'b0; wcyc = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick = 0; cmd_v = 0; code = 0; trig = 0; win = 0; cs = 1;
        vlow = 0; vhot = 0; vsup = 1; bfail = 0; nstop = 0;
        fwu = 0; cyc = 0; wbus = 0; wfrc = 0; wcyc = 0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic to_nreq();
        do_reset(); step(); ticks(P_RST); step();
    endtask

    task automatic to_normal();
        to_nreq(); refresh();
    endtask

    task automatic to_stop();
        to_normal(); cmd(3'd3); cs_pulse();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step();
        chk("R1 mode in reset", mode, 0);
        chk("R1 rst_o in reset", rsto, 1);
        chk("R1 wd_to in reset", wdto, 0);
        do_reset(); step();
        chk("R1 first edge to Reset", mode, 1);
        ticks(P_RST - 1); step();
        chk("R2 still Reset before period", mode, 1);
        chk("R2 rst_o high in Reset", rsto, 1);
        ticks(1); step();
        chk("R2 Normal Request after period", mode, 2);
        chk("R2 rst_o low in Normal Request", rsto, 0);
    endtask

    task automatic t_nreq();
        to_nreq(); refresh();
        chk("R3 refresh to Normal", mode, 3);
        to_nreq(); nstop = 1'b1;
        ticks(P_NREQ - 1); step();
        chk("R3 waiting in Normal Request", mode, 2);
        ticks(1); step();
        chk("R3 timeout with no-stop to Reset", mode, 1);
        chk("R3 timeout flag", wdto, 1);
        to_nreq(); ticks(P_NREQ); step();
        chk("R3 timeout to Sleep", mode, 6);
        wake_pulse(0);
        chk("R10 bus wake from Sleep to Reset", mode, 1);
    endtask

    task automatic t_wd();
        to_normal(); ticks(P_WD - 1); step();
        chk("R4 Normal before timeout", mode, 3);
        ticks(1); step();
        chk("R4 timeout to Reset", mode, 1);
        chk("R4 timeout flag set", wdto, 1);
        ticks(P_RST); step();
        chk("R4 flag held into Normal Request", wdto, 1);
        refresh();
        chk("R4 refresh clears flag", wdto, 0);
        ticks(P_WD - 3); refresh(); ticks(P_WD - 1); step();
        chk("R4 refresh restarts count", mode, 3);
    endtask

    task automatic t_window();
        to_normal(); win = 1'b1; ticks(P_WIN - 1); refresh();
        chk("R5 early refresh to Reset", mode, 1);
        chk("R5 early refresh flag", wdto, 1);
        to_normal(); win = 1'b1; ticks(P_WIN); refresh();
        chk("R5 refresh inside window stays Normal", mode, 3);
    endtask

    task automatic t_stby();
        to_normal(); cmd(3'd2); refresh();
        chk("R6 standby pair from Normal", mode, 4);
        cmd(3'd1);
        chk("R14 normal command from Standby", mode, 3);
        cmd(3'd2); cs_pulse(); refresh();
        chk("R6 interrupted pair discarded", mode, 3);
        to_nreq(); cmd(3'd2); refresh();
        chk("R6 standby pair from Normal Request", mode, 4);
        ticks(P_WD); step();
        chk("R4 Standby timeout to Reset", mode, 1);
    endtask

    task automatic t_stop();
        to_stop();
        chk("R7 stop pair enters Stop", mode, 5);
        wake_pulse(0);
        chk("R10 bus wake from Stop", mode, 2);
        to_normal(); cmd(3'd3); refresh(); cs_pulse();
        chk("R7 interrupted stop pair discarded", mode, 3);
        nstop = 1'b1; cmd(3'd3); cs_pulse();
        chk("R7 no-stop blocks Stop", mode, 3);
        to_stop(); cs_pulse();
        chk("R10 chip-select wake from Stop", mode, 2);
    endtask

    task automatic t_sleep();
        to_normal(); bfail = 1'b1; cmd(3'd4);
        chk("R8 battery-fail blocks Sleep", mode, 3);
        bfail = 1'b0; nstop = 1'b1; cmd(3'd4);
        chk("R8 no-stop blocks Sleep", mode, 3);
        nstop = 1'b0; cmd(3'd4);
        chk("R8 sleep command", mode, 6);
        cs_pulse();
        chk("R10 chip-select wake from Sleep", mode, 1);
    endtask

    task automatic t_supply();
        to_normal(); vlow = 1'b1; cmd_v = 1'b1; code = 3'd4; step();
        cmd_v = 1'b0; code = 3'd0; vlow = 1'b0;
        chk("R9 supply low beats sleep command", mode, 1);
        to_normal(); cmd(3'd2); refresh(); vhot = 1'b1; step(); vhot = 1'b0;
        chk("R9 hot supply in Standby to Reset", mode, 1);
    endtask

    task automatic t_wakesel();
        to_stop(); fwu = 1'b1; cyc = 1'b1; wake_pulse(2);
        chk("R11 cyclic ignored with forced enabled", mode, 5);
        wake_pulse(1);
        chk("R11 forced wake accepted", mode, 2);
        to_stop(); cyc = 1'b1; wake_pulse(1);
        chk("R11 forced ignored when disabled", mode, 5);
        wake_pulse(2);
        chk("R11 cyclic wake accepted", mode, 2);
    endtask

    task automatic t_stopwd();
        to_stop(); ticks(P_STOP - 1); step();
        chk("R12 Stop before timeout", mode, 5);
        ticks(1); step();
        chk("R12 Stop timeout to Reset", mode, 1);
        chk("R12 Stop timeout flag", wdto, 1);
        to_stop(); win = 1'b1; refresh();
        chk("R12 early refresh in Stop tolerated", mode, 5);
        ticks(5); refresh(); ticks(P_STOP - 1); step();
        chk("R12 refresh in Stop restarts count", mode, 5);
    endtask

    task automatic t_forced();
        do_reset(); step(); vhot = 1'b1; step();
        chk("R13 hot supply in Reset to Sleep", mode, 6);
        do_reset(); step(); vlow = 1'b1; ticks(P_LOW - 1); step();
        chk("R13 short low stays Reset", mode, 1);
        ticks(1); step();
        chk("R13 long low to Sleep", mode, 6);
        do_reset(); step(); nstop = 1'b1; vhot = 1'b1; step(); step();
        chk("R13 no-stop keeps Reset", mode, 1);
        do_reset(); step(); vsup = 1'b0; vhot = 1'b1; step(); step();
        chk("R13 weak battery keeps Reset", mode, 1);
    endtask

    initial begin
        t_reset();
        t_nreq();
        t_wd();
        t_window();
        t_stby();
        t_stop();
        t_sleep();
        t_supply();
        t_wakesel();
        t_stopwd();
        t_forced();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule